// File: doc/BRIEF.md
# In-Band Repeating Code Generator

This block produces a serial T1 payload bit stream that repeats a programmable code for as long as a loop-code enable is held. Two 8-bit code inputs hold the code. The first input carries the leading bits, and the second input extends the code when a 16-bit length is chosen. A 4-bit length select picks a pattern length of 1 to 8 bits or exactly 16 bits. The code is left-justified and sent MSB first.

A free-running 193-bit frame counter marks the framing-bit position of each frame. When frame-bit insertion is enabled, the bit at that position is replaced by the supplied framing bit. The code pointer keeps advancing underneath the overwrite, so the code keeps its phase against the raw bit count. While the loop-code enable is low, the output carries a pass-through data input with one bit clock of delay. Raising the enable again starts the code from its first bit.

Top module: `ibc_code_gen`

## Requirements
- R1: While `rst_n` is low, `ser_out` and `frame_strobe` are 0. The first bit clock after release is a frame-bit position, so `frame_strobe` is 1 after that edge.
- R2: `frame_strobe` is high for exactly one bit in every 193, and its rising edges are 193 clocks apart.
- R3: A length select of 1 to 8 gives a code of that many bits. The bits are taken from `code_a` starting at bit 7 and moving downward, and the code then repeats.
- R4: A length select of 0 gives a 5-bit code. With `code_a` = 80h the stream is 1,0,0,0,0 repeated.
- R5: A length select of 9 to 15 gives a 16-bit code: `code_a` bit 7 down to bit 0, then `code_b` bit 7 down to bit 0.
- R6: When `fbit_ins_en` is 1, the bit sent at each frame-bit position (where `frame_strobe` is 1) equals `fbit_val` as sampled at that edge.
- R7: A frame-bit overwrite still advances the code pointer. The bit after the overwrite is the one the code would have sent had no overwrite happened.
- R8: When `fbit_ins_en` is 0, the code bit is sent unchanged at the frame-bit position.
- R9: While `loop_en` is 0, `ser_out` after each edge equals `pass_in` as sampled at that edge, except at frame-bit positions with insertion enabled.
- R10: After `loop_en` has been low for at least one edge, the first code bit sent once it is high again is the first bit of the code.
- R11: For lengths of 8 bits or fewer, `code_b` has no effect on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_a | input | 8 | Leading code byte, MSB sent first |
| code_b | input | 8 | Trailing code byte, used for 16-bit lengths only |
| len_sel | input | 4 | Length select: 1 to 8 give that length, 0 gives 5, 9 to 15 give 16 |
| loop_en | input | 1 | Send the repeating code when 1, pass-through when 0 |
| fbit_ins_en | input | 1 | Overwrite the frame-bit position with `fbit_val` |
| fbit_val | input | 1 | Framing bit value |
| pass_in | input | 1 | Pass-through payload bit |
| ser_out | output | 1 | Serial output bit, registered |
| frame_strobe | output | 1 | High while `ser_out` holds the frame-bit position |

## Verification
The bench builds the block with its default parameters: an 8-bit code width, which gives 16-bit long codes, a 193-bit frame and a 4-bit select. Every select value from 0 to 15, and every crossing of a frame bit at several code phases, can therefore be reached within a few hundred clocks per scenario. With frame lengths that are not multiples of any code length, the overwrite lands on a different code phase in each frame. This exposes any pointer that stalls or skips at the frame bit.

// File: rtl/ibc_pkg.sv
package ibc_pkg;

  // Length decode: 1..code_w literal, 0 maps to def_len, larger values to double width.
  function automatic int ibc_len_of(int sel, int code_w, int def_len);
    if (sel == 0) return def_len;
    if (sel <= code_w) return sel;
    return 2 * code_w;
  endfunction

  // Code pointer step with wrap at the selected length.
  function automatic int ibc_ptr_step(int ptr, int len);
    if (ptr >= len - 1) return 0;
    return ptr + 1;
  endfunction

  // Frame position step with wrap at the frame length.
  function automatic int ibc_frame_step(int cnt, int flen);
    if (cnt >= flen - 1) return 0;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/ibc_len_decode.sv
module ibc_len_decode #(
  parameter int SEL_W   = 4,
  parameter int CODE_W  = 8,
  parameter int DEF_LEN = 5,
  localparam int LEN_W  = $clog2(2 * CODE_W + 1)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LEN_W-1:0] len
);
  import ibc_pkg::*;

  always_comb begin
    len = LEN_W'(ibc_len_of(int'(sel), CODE_W, DEF_LEN));
  end
endmodule

// File: rtl/ibc_frame_counter.sv
module ibc_frame_counter #(
  parameter int FRAME_LEN = 193,
  localparam int FCNT_W   = $clog2(FRAME_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  output logic at_fbit
);
  import ibc_pkg::*;

  logic [FCNT_W-1:0] cnt_q;
  logic [FCNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = FCNT_W'(ibc_frame_step(int'(cnt_q), FRAME_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_fbit = (cnt_q == '0);
endmodule

// File: rtl/ibc_pattern_ptr.sv
module ibc_pattern_ptr #(
  parameter int CODE_W  = 8,
  localparam int PTR_W  = $clog2(2 * CODE_W),
  localparam int LEN_W  = $clog2(2 * CODE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  output logic [PTR_W-1:0] ptr
);
  import ibc_pkg::*;

  logic [PTR_W-1:0] ptr_d;

  // Pointer advances on every enabled bit, frame bits included.
  always_comb begin
    if (!en) ptr_d = '0;
    else     ptr_d = PTR_W'(ibc_ptr_step(int'(ptr), int'(len)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end
endmodule

// File: rtl/ibc_bit_mux.sv
module ibc_bit_mux #(
  parameter int CODE_W  = 8,
  localparam int WORD_W = 2 * CODE_W,
  localparam int PTR_W  = $clog2(WORD_W)
) (
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic [PTR_W-1:0]  ptr,
  output logic              bit_o
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] send_order;

  assign word = {code_a, code_b};

  // send_order[i] is the i-th bit on the line: MSB of code_a first.
  for (genvar i = 0; i < WORD_W; i++) begin : g_order
    assign send_order[i] = word[WORD_W-1-i];
  end

  assign bit_o = send_order[ptr];
endmodule

// File: rtl/ibc_out_stage.sv
module ibc_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic pat_bit,
  input  logic pass_in,
  input  logic fbit_ins_en,
  input  logic fbit_val,
  input  logic at_fbit,
  output logic ser_out,
  output logic frame_strobe
);
  logic overwrite;
  logic ser_d;

  assign overwrite = fbit_ins_en & at_fbit;

  always_comb begin
    if (overwrite)    ser_d = fbit_val;
    else if (loop_en) ser_d = pat_bit;
    else              ser_d = pass_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out      <= 1'b0;
      frame_strobe <= 1'b0;
    end else begin
      ser_out      <= ser_d;
      frame_strobe <= at_fbit;
    end
  end
endmodule

// File: rtl/ibc_code_gen.sv
module ibc_code_gen #(
  parameter int CODE_W    = 8,
  parameter int SEL_W     = 4,
  parameter int DEF_LEN   = 5,
  parameter int FRAME_LEN = 193,
  localparam int PTR_W    = $clog2(2 * CODE_W),
  localparam int LEN_W    = $clog2(2 * CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic [SEL_W-1:0]  len_sel,
  input  logic              loop_en,
  input  logic              fbit_ins_en,
  input  logic              fbit_val,
  input  logic              pass_in,
  output logic              ser_out,
  output logic              frame_strobe
);
  // Named internal events, observed by the bound checker.
  logic [LEN_W-1:0] pat_len_w;
  logic [PTR_W-1:0] pat_ptr_w;
  logic             pat_bit_w;
  logic             at_fbit_w;

  ibc_len_decode #(.SEL_W(SEL_W), .CODE_W(CODE_W), .DEF_LEN(DEF_LEN)) u_len (
    .sel (len_sel),
    .len (pat_len_w)
  );

  ibc_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .at_fbit (at_fbit_w)
  );

  ibc_pattern_ptr #(.CODE_W(CODE_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (loop_en),
    .len   (pat_len_w),
    .ptr   (pat_ptr_w)
  );

  ibc_bit_mux #(.CODE_W(CODE_W)) u_mux (
    .code_a (code_a),
    .code_b (code_b),
    .ptr    (pat_ptr_w),
    .bit_o  (pat_bit_w)
  );

  ibc_out_stage u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .loop_en      (loop_en),
    .pat_bit      (pat_bit_w),
    .pass_in      (pass_in),
    .fbit_ins_en  (fbit_ins_en),
    .fbit_val     (fbit_val),
    .at_fbit      (at_fbit_w),
    .ser_out      (ser_out),
    .frame_strobe (frame_strobe)
  );
endmodule

// File: rtl/ibc_code_gen_chk.sv
module ibc_code_gen_chk #(
  parameter int FRAME_LEN = 193,
  parameter int PTR_W     = 4,
  localparam int GAP_W    = $clog2(FRAME_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loop_en,
  input logic             fbit_ins_en,
  input logic             fbit_val,
  input logic             pass_in,
  input logic             at_fbit,
  input logic [PTR_W-1:0] pat_ptr,
  input logic             ser_out,
  input logic             frame_strobe
);
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_strobe) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + GAP_W'(1);
    end
  end

  // R2: strobes are exactly one frame apart
  assert_strobe_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && seen_q) |-> (gap_q == GAP_W'(FRAME_LEN)));

  // R6: frame-bit position carries the framing bit
  assert_fbit_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fbit_ins_en && at_fbit) |=> (frame_strobe && ser_out == $past(fbit_val)));

  // R9: pass-through when the loop code is off
  assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !(fbit_ins_en && at_fbit)) |=> (ser_out == $past(pass_in)));

  // R10: disabled loop parks the pointer on the first code bit
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (pat_ptr == '0));
endmodule

bind ibc_code_gen ibc_code_gen_chk #(.FRAME_LEN(FRAME_LEN), .PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .loop_en      (loop_en),
  .fbit_ins_en  (fbit_ins_en),
  .fbit_val     (fbit_val),
  .pass_in      (pass_in),
  .at_fbit      (at_fbit_w),
  .pat_ptr      (pat_ptr_w),
  .ser_out      (ser_out),
  .frame_strobe (frame_strobe)
);

// File: tb/ibc_code_gen_tb.sv
module ibc_code_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code_a = 8'h00;
  logic [7:0] code_b = 8'h00;
  logic [3:0] len_sel = 4'd0;
  logic       loop_en = 1'b0;
  logic       fbit_ins_en = 1'b0;
  logic       fbit_val = 1'b0;
  logic       pass_in = 1'b0;
  logic       ser_out;
  logic       frame_strobe;

  int vecs = 0;
  int errs = 0;
  int raw  = 0;
  int pidx = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ibc_code_gen u_dut (
    .clk (clk), .rst_n (rst_n), .code_a (code_a), .code_b (code_b),
    .len_sel (len_sel), .loop_en (loop_en), .fbit_ins_en (fbit_ins_en),
    .fbit_val (fbit_val), .pass_in (pass_in), .ser_out (ser_out),
    .frame_strobe (frame_strobe)
  );

  function automatic int m_len(input logic [3:0] s);
    case (s)
      4'd0:                                           return 5;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: return int'(s);
      default:                                        return 16;
    endcase
  endfunction

  function automatic logic m_code_bit(input int idx);
    if (idx < 8) return code_a[7 - idx];
    return code_b[15 - idx];
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %b expected %b (raw bit %0d)", req, what, act, exp, raw);
    end
  endtask

  // One bit clock: inputs are stable now (negedge), predict, clock, compare.
  task automatic step(input string req);
    logic e_strobe, e_bit;
    int   ln;
    ln       = m_len(len_sel);
    e_strobe = (raw % 193) == 0;
    if (fbit_ins_en && e_strobe) e_bit = fbit_val;
    else if (loop_en)            e_bit = m_code_bit(pidx);
    else                         e_bit = pass_in;
    @(posedge clk);
    @(negedge clk);
    check(req, ser_out, e_bit, "ser_out");
    check(req, frame_strobe, e_strobe, "frame_strobe");
    raw++;
    if (!loop_en)          pidx = 0;
    else if (pidx >= ln-1) pidx = 0;
    else                   pidx = pidx + 1;
  endtask

  task automatic setup(input logic [7:0] a, input logic [7:0] b, input logic [3:0] s, input logic fi);
    loop_en = 1'b0;
    step("R9");
    code_a = a; code_b = b; len_sel = s; fbit_ins_en = fi;
    loop_en = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", ser_out, 1'b0, "ser_out in reset");
    check("R1", frame_strobe, 1'b0, "frame_strobe in reset");
    @(negedge clk);
    rst_n = 1'b1;
    raw = 0; pidx = 0;
  endtask

  task automatic t_reset_r1();
    loop_en = 1'b1; code_a = 8'hFF; len_sel = 4'd8;
    do_reset();
    step("R1");
    check("R1", frame_strobe, 1'b1, "first bit after reset is frame bit");
    for (int i = 0; i < 10; i++) step("R1");
  endtask

  task automatic t_strobe_r2();
    int seen;
    seen = 0;
    loop_en = 1'b0; fbit_ins_en = 1'b0;
    for (int i = 0; i < 400; i++) begin
      pass_in = i[2] ^ i[0];
      step("R2");
      if (frame_strobe) seen++;
    end
    check("R2", 1'(seen == 2 || seen == 3), 1'b1, "strobe count in 400 bits");
  endtask

  task automatic t_short_r3();
    logic [7:0] codes [8] = '{8'hA5, 8'h3C, 8'hC0, 8'h96, 8'h6D, 8'hB4, 8'hE1, 8'h81};
    for (int s = 1; s <= 8; s++) begin
      setup(codes[s-1], 8'h00, 4'(s), 1'b0);
      for (int i = 0; i < 40; i++) step("R3");
    end
  endtask

  task automatic t_default_r4();
    logic [9:0] want;
    want = 10'b1000010000;
    setup(8'h80, 8'h00, 4'd0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      step("R4");
      check("R4", ser_out, want[9 - i], "80h five-bit stream");
    end
    setup(8'h80, 8'h00, 4'd5, 1'b0);
    for (int i = 0; i < 20; i++) step("R4");
  endtask

  task automatic t_long_r5();
    setup(8'hC3, 8'h5A, 4'd9, 1'b0);
    for (int i = 0; i < 48; i++) step("R5");
    setup(8'h1E, 8'hF0, 4'd15, 1'b0);
    for (int i = 0; i < 48; i++) step("R5");
  endtask

  task automatic t_fbit_r6_r7();
    setup(8'hB2, 8'h00, 4'd7, 1'b1);
    for (int i = 0; i < 600; i++) begin
      fbit_val = i[3];
      step("R6/R7");
    end
    setup(8'h9C, 8'h47, 4'd12, 1'b1);
    for (int i = 0; i < 420; i++) begin
      fbit_val = ~i[4];
      step("R7");
    end
  endtask

  task automatic t_nofbit_r8();
    fbit_val = 1'b0;
    setup(8'hE0, 8'h00, 4'd3, 1'b0);
    for (int i = 0; i < 400; i++) step("R8");
  endtask

  task automatic t_pass_r9();
    fbit_ins_en = 1'b1;
    loop_en = 1'b0;
    for (int i = 0; i < 250; i++) begin
      pass_in  = 1'($urandom_range(1));
      fbit_val = 1'($urandom_range(1));
      step("R9");
    end
  endtask

  task automatic t_restart_r10();
    setup(8'h4B, 8'h00, 4'd6, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      for (int i = 0; i < k + 2; i++) step("R10");
      loop_en = 1'b0;
      step("R10");
      loop_en = 1'b1;
      step("R10");
      check("R10", ser_out, 1'b0, "first bit after re-enable is code_a[7]");
    end
  endtask

  task automatic t_ignore_r11();
    setup(8'hD3, 8'h00, 4'd8, 1'b0);
    for (int i = 0; i < 64; i++) begin
      code_b = 8'($urandom);
      step("R11");
    end
    setup(8'h5F, 8'hFF, 4'd4, 1'b0);
    for (int i = 0; i < 32; i++) begin
      code_b = ~code_b;
      step("R11");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_r1();
    t_strobe_r2();
    t_short_r3();
    t_default_r4();
    t_long_r5();
    t_fbit_r6_r7();
    t_nofbit_r8();
    t_pass_r9();
    t_restart_r10();
    t_ignore_r11();
    t_reset_r1();
    finish_run();
  end
endmodule